// File: doc/BRIEF.md
# Dual-Bus Data Space Access Checker

This block sits between a DSP core's address generators and its data memory. The data space is split into a lower X region and an upper Y region by a fixed boundary set at elaboration. An X port carries ordinary reads and every write. A read-only Y port is used only by dual-operand multiply-accumulate prefetches. For each request the block classifies the effective address against the boundary and the top of implemented memory. It decides whether the access is allowed for the operation and, for prefetches, for the pointer register that produced it. It then drives the memory enables, or it suppresses the access and returns an all-zero word in its place.

Ordinary reads and writes see X and Y as one linear byte-addressed space and always use the X port. A prefetch is stricter. Its X slot must come from pointer register 8 or 9 and fall in X space. Its Y slot must come from pointer register 10 or 11 and fall in implemented Y space. Any other combination yields zero and no fault. Read results appear one cycle after the request, and each port carries a flag that marks a forced-zero result.

Top module: `dspace_guard`

## Requirements
- R1: While reset is asserted and in the cycle after it, `x_rvalid`, `y_rvalid`, `x_zeroed` and `y_zeroed` are low. With `req_valid` low, `xmem_en`, `ymem_en` and `xmem_we` stay low.
- R2: Operation codes on `req_op` are 0 plain read, 1 plain write, 2 MAC prefetch and 3 accumulator write-back. A plain read to any implemented address (EA below MEM_END, in either region) drives `xmem_en` and `xmem_addr` = EA[15:1]. One cycle later it gives `x_rvalid` = 1 and `x_rdata` equal to the stored word. For word reads, EA bit 0 is ignored.
- R3: A plain read with `req_byte` = 1 returns only one byte, in `x_rdata[7:0]`, with bits 15:8 zero. EA bit 0 = 0 selects stored bits 7:0, and EA bit 0 = 1 selects stored bits 15:8.
- R4: A plain read at EA >= MEM_END does not enable memory. One cycle later it returns `x_rdata` = 0x0000 with `x_zeroed` = 1.
- R5: In a MAC prefetch the X slot is read as a word, whatever `req_byte` says. It is served only when `x_ptr` is 8 or 9 and EA < Y_BASE. Otherwise `xmem_en` stays low, and one cycle later `x_rdata` = 0 and `x_zeroed` = 1.
- R6: In a MAC prefetch the Y slot is served, in the same cycle as the X slot, only when `y_ptr` is 10 or 11 and Y_BASE <= EA < MEM_END. Then `ymem_en` is high, and one cycle later `y_rvalid` = 1 and `y_rdata` is the stored word. Otherwise `y_rdata` = 0 and `y_zeroed` = 1.
- R7: For every operation other than a MAC prefetch, the Y inputs are ignored. `ymem_en` stays low and `y_rvalid` is low in the following cycle.
- R8: A plain write goes over the X bus to any implemented address in either region. A word write sets `xmem_we` = 2'b11 and carries `wr_data`. A byte write sets only `xmem_we[0]` (bits 7:0, EA bit 0 = 0) or only `xmem_we[1]` (bits 15:8, EA bit 0 = 1), with `wr_data[7:0]` on that lane.
- R9: An accumulator write-back is always a full-word write (`xmem_we` = 2'b11), even when `req_byte` = 1, to any implemented address in either region.
- R10: A write at EA >= MEM_END leaves `xmem_we` at zero, so memory is unchanged. No write gives a read result (`x_rvalid` low one cycle later).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | Operation code (see R2) |
| x_ea | input | AW | X-slot byte effective address |
| x_ptr | input | 4 | Pointer register that formed `x_ea` |
| y_ea | input | AW | Y-slot byte effective address (MAC only) |
| y_ptr | input | 4 | Pointer register that formed `y_ea` |
| req_byte | input | 1 | Byte-sized access |
| wr_data | input | 16 | Write data |
| xmem_en | output | 1 | X port memory enable |
| xmem_we | output | 2 | X port byte-lane write enables |
| xmem_addr | output | AW-1 | X port word address |
| xmem_wdata | output | 16 | X port write data |
| xmem_rdata | input | 16 | X port read data, one cycle after enable |
| ymem_en | output | 1 | Y port memory enable (read only) |
| ymem_addr | output | AW-1 | Y port word address |
| ymem_rdata | input | 16 | Y port read data, one cycle after enable |
| x_rvalid | output | 1 | X read result valid |
| x_rdata | output | 16 | X read result |
| x_zeroed | output | 1 | X read result was forced to zero |
| y_rvalid | output | 1 | Y read result valid |
| y_rdata | output | 16 | Y read result |
| y_zeroed | output | 1 | Y read result was forced to zero |

## Verification
The bench builds the block with a 16-bit address, Y_BASE = 0x20 and MEM_END = 0x40. That gives 16 words of X space and 16 words of Y space backed by a 32-word model, so every implemented byte address and a band of unimplemented ones above it can be swept for byte and word reads. With this small space, the MAC prefetch sweep pairs every pointer number 0 to 15 with addresses on both sides of the boundary and past the memory top. The checks then cover the zone edges at 0x1E/0x20 and 0x3E/0x40, plus the far end at 0xFFFE/0xFFFF.

// File: rtl/dspace_pkg.sv
// Shared types for the dual-bus data space checker.
// Assumes 16-bit data words made of two byte lanes.
package dspace_pkg;
    localparam int unsigned DW = 16;
    localparam int unsigned LANES = DW / 8;

    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_MAC   = 2'd2,
        OP_ACCWB = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ZN_X    = 2'd0,
        ZN_Y    = 2'd1,
        ZN_NONE = 2'd2
    } zone_e;

    // Pointer registers tied to each space during MAC prefetch
    localparam logic [3:0] PX_A = 4'd8;
    localparam logic [3:0] PX_B = 4'd9;
    localparam logic [3:0] PY_A = 4'd10;
    localparam logic [3:0] PY_B = 4'd11;

    // Deferred description of a read, carried to the return cycle
    typedef struct packed {
        logic valid;
        logic zero;
        logic byte_rd;
        logic hi;
    } ret_t;
endpackage

// File: rtl/dspace_region.sv
// Classifies a byte effective address into X space, Y space or
// unimplemented. Assumes Y_BASE <= MEM_END <= 2**AW.
module dspace_region
    import dspace_pkg::*;
#(
    parameter int unsigned AW      = 16,
    parameter int unsigned Y_BASE  = 32'h0800,
    parameter int unsigned MEM_END = 32'h1000
) (
    input  logic [AW-1:0] ea,
    output zone_e         zone
);
    localparam logic [AW:0] YB = (AW+1)'(Y_BASE);
    localparam logic [AW:0] ME = (AW+1)'(MEM_END);

    // Compare the widened address against both fixed limits
    always_comb begin
        if ({1'b0, ea} >= ME)      zone = ZN_NONE;
        else if ({1'b0, ea} >= YB) zone = ZN_Y;
        else                       zone = ZN_X;
    end
endmodule

// File: rtl/dspace_xctl.sv
// X port controller: decides legality of reads, writes and MAC
// X-slot prefetches, and drives enables and lane write strobes.
// Assumes the memory registers read data on the enabling edge.
module dspace_xctl
    import dspace_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          valid,
    input  op_e           op,
    input  logic [AW-1:0] ea,
    input  logic [3:0]    ptr,
    input  logic          byte_req,
    input  logic [DW-1:0] wdata_in,
    input  zone_e         zone,
    output logic          mem_en,
    output logic [LANES-1:0] mem_we,
    output logic [AW-2:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output ret_t          ret
);
    logic is_mac, is_wr, is_rd, ptr_ok, rd_ok, wr_ok, byte_wr;

    // Operation decode and legality terms
    always_comb begin
        is_mac  = (op == OP_MAC);
        is_wr   = (op == OP_WRITE) || (op == OP_ACCWB);
        is_rd   = !is_wr;
        ptr_ok  = (ptr == PX_A) || (ptr == PX_B);
        rd_ok   = is_mac ? (ptr_ok && zone == ZN_X) : (zone != ZN_NONE);
        wr_ok   = (zone != ZN_NONE);
        byte_wr = (op == OP_WRITE) && byte_req;
    end

    // Memory-side drive: enable, lane strobes, address and data
    always_comb begin
        mem_en    = valid && (is_rd ? rd_ok : wr_ok);
        mem_we    = '0;
        if (valid && is_wr && wr_ok) begin
            if (byte_wr) mem_we = ea[0] ? 2'b10 : 2'b01;
            else         mem_we = 2'b11;
        end
        mem_addr  = ea[AW-1:1];
        mem_wdata = byte_wr ? {wdata_in[7:0], wdata_in[7:0]} : wdata_in;
    end

    // Read descriptor handed to the return stage
    always_comb begin
        ret.valid   = valid && is_rd;
        ret.zero    = valid && is_rd && !rd_ok;
        ret.byte_rd = (op == OP_READ) && byte_req;
        ret.hi      = ea[0];
    end
endmodule

// File: rtl/dspace_yctl.sv
// Y port controller: serves only MAC Y-slot prefetches, word sized,
// from pointer registers 10/11 into implemented Y space.
module dspace_yctl
    import dspace_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic          valid,
    input  op_e           op,
    input  logic [AW-1:0] ea,
    input  logic [3:0]    ptr,
    input  zone_e         zone,
    output logic          mem_en,
    output logic [AW-2:0] mem_addr,
    output ret_t          ret
);
    logic active, legal;

    // Prefetch legality for the Y slot
    always_comb begin
        active = valid && (op == OP_MAC);
        legal  = ((ptr == PY_A) || (ptr == PY_B)) && (zone == ZN_Y);
    end

    // Memory enable and return descriptor
    always_comb begin
        mem_en      = active && legal;
        mem_addr    = ea[AW-1:1];
        ret.valid   = active;
        ret.zero    = active && !legal;
        ret.byte_rd = 1'b0;
        ret.hi      = 1'b0;
    end
endmodule

// File: rtl/dspace_ret.sv
// Return stage for one read port: holds the read descriptor for one
// cycle and either passes memory data (optionally one byte) or zero.
module dspace_ret
    import dspace_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  ret_t          ret_in,
    input  logic [DW-1:0] mem_rdata,
    output logic          rvalid,
    output logic [DW-1:0] rdata,
    output logic          zeroed
);
    ret_t q;

    // Register the descriptor alongside the memory's own read register
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= ret_in;
    end

    // Shape the result: zero, low-justified byte, or whole word
    always_comb begin
        rvalid = q.valid;
        zeroed = q.valid && q.zero;
        if (!q.valid || q.zero) rdata = '0;
        else if (q.byte_rd)     rdata = {8'h00, q.hi ? mem_rdata[15:8] : mem_rdata[7:0]};
        else                    rdata = mem_rdata;
    end
endmodule

// File: rtl/dspace_guard.sv
// Top of the dual-bus data space access checker. Two address
// classifiers feed an X controller (reads, writes, MAC X slot) and a
// Y controller (MAC Y slot only); each port has a one-cycle return
// stage. Assumes synchronous memories with one-cycle read latency.
module dspace_guard
    import dspace_pkg::*;
#(
    parameter int unsigned AW      = 16,
    parameter int unsigned Y_BASE  = 32'h0800,
    parameter int unsigned MEM_END = 32'h1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] x_ea,
    input  logic [3:0]    x_ptr,
    input  logic [AW-1:0] y_ea,
    input  logic [3:0]    y_ptr,
    input  logic          req_byte,
    input  logic [15:0]   wr_data,
    output logic          xmem_en,
    output logic [1:0]    xmem_we,
    output logic [AW-2:0] xmem_addr,
    output logic [15:0]   xmem_wdata,
    input  logic [15:0]   xmem_rdata,
    output logic          ymem_en,
    output logic [AW-2:0] ymem_addr,
    input  logic [15:0]   ymem_rdata,
    output logic          x_rvalid,
    output logic [15:0]   x_rdata,
    output logic          x_zeroed,
    output logic          y_rvalid,
    output logic [15:0]   y_rdata,
    output logic          y_zeroed
);
    localparam int unsigned NPORT = 2;

    op_e           op;
    logic [AW-1:0] ea_v   [NPORT];
    zone_e         zone_v [NPORT];
    ret_t          xret, yret;

    // Cast the raw operation code and gather per-port addresses
    always_comb begin
        op      = op_e'(req_op);
        ea_v[0] = x_ea;
        ea_v[1] = y_ea;
    end

    // One fixed-boundary classifier per address port
    for (genvar p = 0; p < NPORT; p++) begin : g_zone
        dspace_region #(.AW(AW), .Y_BASE(Y_BASE), .MEM_END(MEM_END)) u_region (
            .ea   (ea_v[p]),
            .zone (zone_v[p])
        );
    end

    dspace_xctl #(.AW(AW)) u_xctl (
        .valid     (req_valid),
        .op        (op),
        .ea        (x_ea),
        .ptr       (x_ptr),
        .byte_req  (req_byte),
        .wdata_in  (wr_data),
        .zone      (zone_v[0]),
        .mem_en    (xmem_en),
        .mem_we    (xmem_we),
        .mem_addr  (xmem_addr),
        .mem_wdata (xmem_wdata),
        .ret       (xret)
    );

    dspace_yctl #(.AW(AW)) u_yctl (
        .valid    (req_valid),
        .op       (op),
        .ea       (y_ea),
        .ptr      (y_ptr),
        .zone     (zone_v[1]),
        .mem_en   (ymem_en),
        .mem_addr (ymem_addr),
        .ret      (yret)
    );

    dspace_ret u_xret (
        .clk       (clk),
        .rst_n     (rst_n),
        .ret_in    (xret),
        .mem_rdata (xmem_rdata),
        .rvalid    (x_rvalid),
        .rdata     (x_rdata),
        .zeroed    (x_zeroed)
    );

    dspace_ret u_yret (
        .clk       (clk),
        .rst_n     (rst_n),
        .ret_in    (yret),
        .mem_rdata (ymem_rdata),
        .rvalid    (y_rvalid),
        .rdata     (y_rdata),
        .zeroed    (y_zeroed)
    );
endmodule

// File: rtl/dspace_guard_chk.sv
// Property checker for dspace_guard, bound to every instance.
// Relates request inputs to memory strobes and next-cycle results.
module dspace_guard_chk #(
    parameter int unsigned AW      = 16,
    parameter int unsigned Y_BASE  = 32'h0800,
    parameter int unsigned MEM_END = 32'h1000
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [1:0]    req_op,
    input logic [AW-1:0] x_ea,
    input logic [3:0]    x_ptr,
    input logic [AW-1:0] y_ea,
    input logic [3:0]    y_ptr,
    input logic          req_byte,
    input logic          xmem_en,
    input logic [1:0]    xmem_we,
    input logic          ymem_en,
    input logic          x_rvalid,
    input logic [15:0]   x_rdata,
    input logic          x_zeroed,
    input logic          y_rvalid,
    input logic [15:0]   y_rdata,
    input logic          y_zeroed
);
    localparam logic [AW:0] YB = (AW+1)'(Y_BASE);
    localparam logic [AW:0] ME = (AW+1)'(MEM_END);

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!x_rvalid && !y_rvalid && !x_zeroed && !y_zeroed));

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op[0]) |=> x_rvalid);

    assert_unimpl_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && {1'b0, x_ea} >= ME) |=> (x_zeroed && x_rdata == 16'h0));

    assert_unimpl_noen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd0 && {1'b0, x_ea} >= ME) |-> !xmem_en);

    assert_mac_xptr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd2 && ((x_ptr != 4'd8 && x_ptr != 4'd9) || {1'b0, x_ea} >= YB))
        |=> (x_zeroed && x_rdata == 16'h0));

    assert_mac_yslot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd2 && y_ptr != 4'd10 && y_ptr != 4'd11)
        |=> (y_rvalid && y_zeroed && y_rdata == 16'h0));

    assert_ybus_mac_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ymem_en |-> (req_valid && req_op == 2'd2));

    assert_y_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_op == 2'd2) |=> !y_rvalid);

    assert_we_on_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (xmem_we != 2'b00) |-> (req_valid && req_op[0] && xmem_en));

    assert_byte_lane_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd1 && req_byte && {1'b0, x_ea} < ME)
        |-> ($countones(xmem_we) == 1 && xmem_we[x_ea[0]]));

    assert_accwb_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == 2'd3 && {1'b0, x_ea} < ME) |-> (xmem_we == 2'b11));

    assert_no_unimpl_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (xmem_we != 2'b00) |-> ({1'b0, x_ea} < ME));

    assert_no_ret_on_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op[0]) |=> !x_rvalid);
endmodule

bind dspace_guard dspace_guard_chk #(.AW(AW), .Y_BASE(Y_BASE), .MEM_END(MEM_END)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .x_ea(x_ea), .x_ptr(x_ptr), .y_ea(y_ea), .y_ptr(y_ptr), .req_byte(req_byte),
    .xmem_en(xmem_en), .xmem_we(xmem_we), .ymem_en(ymem_en),
    .x_rvalid(x_rvalid), .x_rdata(x_rdata), .x_zeroed(x_zeroed),
    .y_rvalid(y_rvalid), .y_rdata(y_rdata), .y_zeroed(y_zeroed)
);

// File: tb/dspace_guard_test.sv
`timescale 1ns/1ps
// Sweep bench for dspace_guard on a 64-byte implemented space.
module dspace_guard_test;
    localparam int AW = 16;
    localparam int YB = 32;
    localparam int ME = 64;
    localparam int NW = ME / 2;
    localparam int WI = $clog2(NW);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_op = 2'd0;
    logic [AW-1:0] x_ea = '0, y_ea = '0;
    logic [3:0]    x_ptr = '0, y_ptr = '0;
    logic          req_byte = 1'b0;
    logic [15:0]   wr_data = '0;
    logic          xmem_en, ymem_en;
    logic [1:0]    xmem_we;
    logic [AW-2:0] xmem_addr, ymem_addr;
    logic [15:0]   xmem_wdata, xmem_rdata, ymem_rdata;
    logic          x_rvalid, x_zeroed, y_rvalid, y_zeroed;
    logic [15:0]   x_rdata, y_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [15:0] store  [NW];
    logic [15:0] shadow [NW];
    logic        cap_xen, cap_yen;
    logic [1:0]  cap_we;

    always #2 clk = ~clk;

    dspace_guard #(.AW(AW), .Y_BASE(YB), .MEM_END(ME)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .x_ea(x_ea), .x_ptr(x_ptr), .y_ea(y_ea), .y_ptr(y_ptr),
        .req_byte(req_byte), .wr_data(wr_data),
        .xmem_en(xmem_en), .xmem_we(xmem_we), .xmem_addr(xmem_addr),
        .xmem_wdata(xmem_wdata), .xmem_rdata(xmem_rdata),
        .ymem_en(ymem_en), .ymem_addr(ymem_addr), .ymem_rdata(ymem_rdata),
        .x_rvalid(x_rvalid), .x_rdata(x_rdata), .x_zeroed(x_zeroed),
        .y_rvalid(y_rvalid), .y_rdata(y_rdata), .y_zeroed(y_zeroed)
    );

    // Synchronous memory model: X read/write port, Y read port
    always_ff @(posedge clk) begin
        if (xmem_en) begin
            if (xmem_we[0]) store[xmem_addr[WI-1:0]][7:0]  <= xmem_wdata[7:0];
            if (xmem_we[1]) store[xmem_addr[WI-1:0]][15:8] <= xmem_wdata[15:8];
            xmem_rdata <= store[xmem_addr[WI-1:0]];
        end
        if (ymem_en) ymem_rdata <= store[ymem_addr[WI-1:0]];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one request at a falling edge, capture strobes, wait a cycle
    task automatic req(input logic [1:0] op, input logic [15:0] xa, input logic [3:0] xp,
                       input logic [15:0] ya, input logic [3:0] yp, input logic b,
                       input logic [15:0] wd);
        req_valid = 1'b1; req_op = op; x_ea = xa; x_ptr = xp;
        y_ea = ya; y_ptr = yp; req_byte = b; wr_data = wd;
        #1;
        cap_xen = xmem_en; cap_we = xmem_we; cap_yen = ymem_en;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [15:0] pat(input int w);
        return 16'((w * 16'h0123) ^ 16'hA55A);
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk(!x_rvalid && !y_rvalid && !x_zeroed && !y_zeroed, "R1 in reset",
            {x_rvalid, y_rvalid, x_zeroed, y_zeroed}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!x_rvalid && !y_rvalid && !xmem_en && !ymem_en && xmem_we == 0, "R1 after reset",
            {x_rvalid, y_rvalid, xmem_en, ymem_en, xmem_we}, 0);

        // R8: fill every word with word writes across both regions
        for (int w = 0; w < NW; w++) begin
            req(2'd1, 16'(2 * w), 4'd1, 16'h0020, 4'd10, 1'b0, pat(w));
            shadow[w] = pat(w);
            chk(cap_we == 2'b11 && cap_xen && !cap_yen, "R8 word write strobes", {cap_yen, cap_xen, cap_we}, 32'h7);
            chk(!x_rvalid && !y_rvalid, "R10 no result after write", {x_rvalid, y_rvalid}, 0);
        end

        // R10: writes beyond implemented memory have no strobe
        for (int a = ME; a < ME + 24; a++) begin
            req(2'd1, 16'(a), 4'd2, '0, 4'd0, a[0], 16'hDEAD);
            chk(cap_we == 2'b00, "R10 unimpl write", cap_we, 0);
        end
        req(2'd3, 16'hFFFE, 4'd8, '0, 4'd0, 1'b0, 16'hBEEF);
        chk(cap_we == 2'b00, "R10 unimpl accwb", cap_we, 0);

        // R2/R3/R4/R7: plain read sweep, byte and word, past the top
        for (int b = 0; b < 2; b++) begin
            for (int a = 0; a < 2 * ME + 2; a++) begin
                logic [15:0] ea, ex;
                logic        imp;
                ea  = (a >= 2 * ME) ? 16'(16'hFFFE + (a - 2 * ME)) : 16'(a);
                imp = (int'(ea) < ME);
                if (!imp)      ex = 16'h0;
                else if (b == 1) ex = {8'h00, ea[0] ? shadow[int'(ea) / 2][15:8] : shadow[int'(ea) / 2][7:0]};
                else           ex = shadow[int'(ea) / 2];
                req(2'd0, ea, 4'd3, 16'h0022, 4'd10, b[0], 16'h0);
                chk(x_rvalid && x_rdata == ex,
                    imp ? (b == 1 ? "R3 byte read" : "R2 word read") : "R4 unimpl read data",
                    {ea, x_rdata}, {ea, ex});
                chk(x_zeroed == !imp && cap_xen == imp, "R4 zero flag and enable",
                    {x_zeroed, cap_xen}, {!imp, imp});
                chk(!cap_yen && !y_rvalid, "R7 Y idle on plain read", {cap_yen, y_rvalid}, 0);
            end
        end

        // R8: byte writes on each lane, read back as words
        for (int a = 0; a < ME; a += 3) begin
            logic [15:0] wd;
            wd = {8'hEE, 8'(a ^ 8'h96)};
            req(2'd1, 16'(a), 4'd4, '0, 4'd0, 1'b1, wd);
            chk(cap_we == (a[0] ? 2'b10 : 2'b01), "R8 byte lane strobe", cap_we, a[0] ? 2 : 1);
            if (a[0]) shadow[a / 2][15:8] = wd[7:0];
            else      shadow[a / 2][7:0]  = wd[7:0];
            req(2'd0, 16'(a & ~1), 4'd4, '0, 4'd0, 1'b0, 16'h0);
            chk(x_rdata == shadow[a / 2], "R8 byte write readback", x_rdata, shadow[a / 2]);
        end

        // R9: accumulator write-back is a full word even with byte flag
        for (int a = 1; a < ME; a += 7) begin
            logic [15:0] wd;
            wd = 16'(16'h7100 + a * 5);
            req(2'd3, 16'(a), 4'd9, '0, 4'd0, 1'b1, wd);
            chk(cap_we == 2'b11, "R9 accwb strobes", cap_we, 3);
            shadow[a / 2] = wd;
            req(2'd0, 16'(a & ~1), 4'd0, '0, 4'd0, 1'b0, 16'h0);
            chk(x_rdata == wd, "R9 accwb readback", x_rdata, wd);
        end

        // R5/R6: MAC prefetch over every pointer and both regions
        for (int xp = 0; xp < 16; xp++) begin
            for (int a = 0; a < ME + 8; a += 2) begin
                logic [15:0] xa, ya, exx, exy;
                logic [3:0]  yp;
                logic        xok, yok;
                xa  = 16'(a);
                ya  = 16'(ME + 6 - a);
                yp  = 4'(8 + (xp % 4));
                xok = (xp == 8 || xp == 9) && a < YB;
                yok = (yp == 4'd10 || yp == 4'd11) && int'(ya) >= YB && int'(ya) < ME;
                exx = xok ? shadow[a / 2] : 16'h0;
                exy = yok ? shadow[int'(ya) / 2] : 16'h0;
                req(2'd2, xa, 4'(xp), ya, yp, xp[0], 16'h0);
                chk(x_rvalid && x_rdata == exx && x_zeroed == !xok && cap_xen == xok,
                    "R5 MAC X slot", {xa, x_rdata, 3'b0, x_zeroed}, {xa, exx, 3'b0, !xok});
                chk(y_rvalid && y_rdata == exy && y_zeroed == !yok && cap_yen == yok,
                    "R6 MAC Y slot", {ya, y_rdata, 3'b0, y_zeroed}, {ya, exy, 3'b0, !yok});
            end
        end

        // R7: Y inputs ignored by writes too
        req(2'd3, 16'h0004, 4'd0, 16'h0030, 4'd11, 1'b0, 16'h1234);
        shadow[2] = 16'h1234;
        chk(!cap_yen && !y_rvalid, "R7 Y idle on accwb", {cap_yen, y_rvalid}, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule